// File: doc/BRIEF.md
# Double-Width Frame Segmenter and Reassembler

This block carries a parallel bus twice as wide as a serial link's native payload. The payload is 16 or 20 bits, so the wide bus is 32 or 40 bits. The transmit half takes wide words through a valid/ready handshake. It emits each word as two consecutive narrow segments, lower half first. A per-segment flag tells the two halves apart: clear on the lower half, set on the upper half.

The receive half watches the narrow frames coming back from the link. Each frame carries a kind code: data, fill or training. The receive half stores a flag-clear data segment as the lower half. When the next data segment arrives with its flag set, it presents the rebuilt wide word. Alignment is recovered from the flag alone, with no inserted sync words. An out-of-order flag raises a one-cycle misalignment pulse and drops the affected segments. A duplex link uses one instance per direction. Encoding and serialization sit outside the block.

Top module: `wf_wide_link`

## Requirements
- R1: One cycle after a wide word is accepted (`tx_wide_valid` and `tx_wide_ready` both high at a rising edge), the segment output carries bits [SEG_W-1:0] of that word with `tx_seg_flag` = 0 and `tx_seg_valid` = 1.
- R2: In the following cycle the segment output carries bits [2*SEG_W-1:SEG_W] of the same word, with `tx_seg_flag` = 1 and `tx_seg_valid` = 1.
- R3: `tx_wide_ready` is low in the cycle the lower half is on the output, so words are accepted at most every second cycle. A word offered during the upper-half cycle is accepted at once, giving gap-free segments.
- R4: With nothing accepted and no upper half pending, `tx_seg_valid` is 0.
- R5: `rx_seg_kind` codes are 2'b00 data, 2'b01 fill, 2'b10 training and 2'b11 reserved (handled as fill). A data frame with flag 0 is stored as the lower half. A following data frame with flag 1 produces `rx_wide_valid` = 1 one cycle later, with `rx_wide_data` = {upper, lower}.
- R6: A data frame with flag 1 and no stored lower half produces no word and pulses `rx_misalign` for one cycle.
- R7: A data frame with flag 0 while a lower half is stored pulses `rx_misalign` and discards both segments. The next flag-0 data frame starts a new word.
- R8: Fill and reserved frames produce no output and leave a stored lower half intact.
- R9: A training frame discards any stored lower half, with no misalignment pulse and no output.
- R10: After synchronous reset, `tx_wide_ready` = 1 and `tx_seg_valid`, `rx_wide_valid` and `rx_misalign` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wide_data | input | 2*SEG_W | Wide word to send |
| tx_wide_valid | input | 1 | Wide word offered |
| tx_wide_ready | output | 1 | Segmenter can take a word |
| tx_seg_data | output | SEG_W | Narrow segment toward the link |
| tx_seg_flag | output | 1 | 0 = lower half, 1 = upper half |
| tx_seg_valid | output | 1 | Segment output holds a segment |
| rx_seg_data | input | SEG_W | Narrow segment from the link |
| rx_seg_flag | input | 1 | Half marker of the incoming segment |
| rx_seg_kind | input | 2 | Frame kind: data, fill, training, reserved |
| rx_wide_data | output | 2*SEG_W | Rebuilt wide word |
| rx_wide_valid | output | 1 | One-cycle pulse with a rebuilt word |
| rx_misalign | output | 1 | One-cycle pulse on a dropped segment |

## Verification
Embedded properties check a number of cycle-level relations on every clock:
- an upper-half segment always follows a lower-half segment on the next cycle, carrying the upper bits accepted two cycles earlier;
- ready stays low while the lower half is on the output;
- a rebuilt word only follows a flag-set data frame and carries that frame's data in its upper half;
- fill, reserved and training frames never produce a word or an error pulse;
- a word and an error pulse never coincide.

Only the bench's scenarios show the remaining behaviours. These are that a stored lower half survives fill frames, that both segments are dropped after a double flag-clear, that training discards a pending half, and that the full rebuilt value is correct.

// File: rtl/wf_pkg.sv
package wf_pkg;

    typedef enum logic [1:0] {
        KIND_DATA  = 2'b00,
        KIND_FILL  = 2'b01,
        KIND_TRAIN = 2'b10,
        KIND_RSVD  = 2'b11
    } seg_kind_e;

    typedef enum logic [2:0] {
        EVT_NONE,
        EVT_STORE,
        EVT_EMIT,
        EVT_ERROR,
        EVT_CLEAR
    } rx_evt_e;

    // Decide what the reassembler does with one incoming frame.
    function automatic rx_evt_e classify(seg_kind_e kind, logic flag, logic have_lower);
        rx_evt_e evt;
        case (kind)
            KIND_DATA: begin
                if (flag) evt = have_lower ? EVT_EMIT  : EVT_ERROR;
                else      evt = have_lower ? EVT_ERROR : EVT_STORE;
            end
            KIND_TRAIN: evt = EVT_CLEAR;
            default:    evt = EVT_NONE;
        endcase
        return evt;
    endfunction

endpackage

// File: rtl/wf_tx_split.sv
module wf_tx_split #(
    parameter int SEG_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2*SEG_W-1:0]   wide_data,
    input  logic                 wide_valid,
    output logic                 wide_ready,
    output logic [SEG_W-1:0]     seg_data,
    output logic                 seg_flag,
    output logic                 seg_valid
);
    localparam int WIDE_W = 2 * SEG_W;

    logic             pend_q;
    logic [SEG_W-1:0] upper_q;
    logic             accept;

    assign wide_ready = !pend_q;
    assign accept     = wide_valid && wide_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            upper_q   <= '0;
            seg_data  <= '0;
            seg_flag  <= 1'b0;
            seg_valid <= 1'b0;
        end else if (accept) begin
            seg_data  <= wide_data[SEG_W-1:0];
            upper_q   <= wide_data[WIDE_W-1:SEG_W];
            seg_flag  <= 1'b0;
            seg_valid <= 1'b1;
            pend_q    <= 1'b1;
        end else if (pend_q) begin
            seg_data  <= upper_q;
            seg_flag  <= 1'b1;
            seg_valid <= 1'b1;
            pend_q    <= 1'b0;
        end else begin
            seg_flag  <= 1'b0;
            seg_valid <= 1'b0;
        end
    end

    AST_UPPER_FOLLOWS_LOWER: assert property (@(posedge clk) disable iff (rst)
        (seg_valid && !seg_flag) |=> (seg_valid && seg_flag)); // R2
    AST_UPPER_HAS_LOWER: assert property (@(posedge clk) disable iff (rst)
        (seg_valid && seg_flag) |-> $past(seg_valid && !seg_flag)); // R2
    AST_UPPER_DATA: assert property (@(posedge clk) disable iff (rst)
        (seg_valid && seg_flag) |-> seg_data == $past(wide_data[WIDE_W-1:SEG_W], 2)); // R2
    AST_READY_LOW_ON_LOWER: assert property (@(posedge clk) disable iff (rst)
        (seg_valid && !seg_flag) |-> !wide_ready); // R3
    AST_LOWER_DATA: assert property (@(posedge clk) disable iff (rst)
        (seg_valid && !seg_flag) |-> seg_data == $past(wide_data[SEG_W-1:0])); // R1

endmodule

// File: rtl/wf_rx_merge.sv
module wf_rx_merge
    import wf_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SEG_W-1:0]     seg_data,
    input  logic                 seg_flag,
    input  logic [1:0]           seg_kind,
    output logic [2*SEG_W-1:0]   wide_data,
    output logic                 wide_valid,
    output logic                 misalign
);
    localparam int WIDE_W = 2 * SEG_W;

    logic             have_lower;
    logic [SEG_W-1:0] lower_q;
    rx_evt_e          evt;

    always_comb evt = classify(seg_kind_e'(seg_kind), seg_flag, have_lower);

    always_ff @(posedge clk) begin
        if (rst) begin
            have_lower <= 1'b0;
            lower_q    <= '0;
            wide_data  <= '0;
            wide_valid <= 1'b0;
            misalign   <= 1'b0;
        end else begin
            wide_valid <= 1'b0;
            misalign   <= 1'b0;
            case (evt)
                EVT_STORE: begin
                    lower_q    <= seg_data;
                    have_lower <= 1'b1;
                end
                EVT_EMIT: begin
                    wide_data  <= {seg_data, lower_q};
                    wide_valid <= 1'b1;
                    have_lower <= 1'b0;
                end
                EVT_ERROR: begin
                    misalign   <= 1'b1;
                    have_lower <= 1'b0;
                end
                EVT_CLEAR: have_lower <= 1'b0;
                default: ;
            endcase
        end
    end

    AST_WORD_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        wide_valid |-> $past(seg_kind == 2'b00 && seg_flag)); // R5
    AST_WORD_UPPER: assert property (@(posedge clk) disable iff (rst)
        wide_valid |-> wide_data[WIDE_W-1:SEG_W] == $past(seg_data)); // R5
    AST_NO_WORD_AND_ERR: assert property (@(posedge clk) disable iff (rst)
        !(wide_valid && misalign)); // R6
    AST_FILL_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(seg_kind[0]) |-> (!wide_valid && !misalign)); // R8
    AST_TRAIN_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(seg_kind == 2'b10) |-> (!wide_valid && !misalign)); // R9

endmodule

// File: rtl/wf_wide_link.sv
module wf_wide_link #(
    parameter int SEG_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2*SEG_W-1:0]   tx_wide_data,
    input  logic                 tx_wide_valid,
    output logic                 tx_wide_ready,
    output logic [SEG_W-1:0]     tx_seg_data,
    output logic                 tx_seg_flag,
    output logic                 tx_seg_valid,
    input  logic [SEG_W-1:0]     rx_seg_data,
    input  logic                 rx_seg_flag,
    input  logic [1:0]           rx_seg_kind,
    output logic [2*SEG_W-1:0]   rx_wide_data,
    output logic                 rx_wide_valid,
    output logic                 rx_misalign
);

    wf_tx_split #(.SEG_W(SEG_W)) u_split (
        .clk        (clk),
        .rst        (rst),
        .wide_data  (tx_wide_data),
        .wide_valid (tx_wide_valid),
        .wide_ready (tx_wide_ready),
        .seg_data   (tx_seg_data),
        .seg_flag   (tx_seg_flag),
        .seg_valid  (tx_seg_valid)
    );

    wf_rx_merge #(.SEG_W(SEG_W)) u_merge (
        .clk        (clk),
        .rst        (rst),
        .seg_data   (rx_seg_data),
        .seg_flag   (rx_seg_flag),
        .seg_kind   (rx_seg_kind),
        .wide_data  (rx_wide_data),
        .wide_valid (rx_wide_valid),
        .misalign   (rx_misalign)
    );

    AST_RESET_READY: assert property (@(posedge clk)
        $past(rst) |-> (tx_wide_ready && !tx_seg_valid && !rx_wide_valid && !rx_misalign)); // R10

endmodule

// File: tb/wf_wide_link_bench.sv
module wf_wide_link_bench;

    localparam int SEG_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [31:0]       tx_wide_data = '0;
    logic              tx_wide_valid = 1'b0;
    logic              tx_wide_ready;
    logic [15:0]       tx_seg_data;
    logic              tx_seg_flag;
    logic              tx_seg_valid;
    logic [15:0]       rx_seg_data = '0;
    logic              rx_seg_flag = 1'b0;
    logic [1:0]        rx_seg_kind = 2'b01;
    logic [31:0]       rx_wide_data;
    logic              rx_wide_valid;
    logic              rx_misalign;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wf_wide_link #(.SEG_W(SEG_W)) u_wf_wide_link (
        .clk(clk), .rst(rst),
        .tx_wide_data(tx_wide_data), .tx_wide_valid(tx_wide_valid),
        .tx_wide_ready(tx_wide_ready), .tx_seg_data(tx_seg_data),
        .tx_seg_flag(tx_seg_flag), .tx_seg_valid(tx_seg_valid),
        .rx_seg_data(rx_seg_data), .rx_seg_flag(rx_seg_flag),
        .rx_seg_kind(rx_seg_kind), .rx_wide_data(rx_wide_data),
        .rx_wide_valid(rx_wide_valid), .rx_misalign(rx_misalign)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  kind;
        logic        flag;
        logic [15:0] din;
        logic        ev;
        logic        ee;
        logic [31:0] ed;
    } vec_t;

    // kind: 00 data, 01 fill, 10 training, 11 reserved
    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{4'd5, 2'b00, 1'b0, 16'hA1A1, 1'b0, 1'b0, 32'h0},          // R5 store
        '{4'd5, 2'b00, 1'b1, 16'hB1B1, 1'b1, 1'b0, 32'hB1B1A1A1},   // R5 emit
        '{4'd8, 2'b01, 1'b0, 16'h0000, 1'b0, 1'b0, 32'h0},          // R8 idle fill
        '{4'd6, 2'b00, 1'b1, 16'hC2C2, 1'b0, 1'b1, 32'h0},          // R6 orphan upper
        '{4'd5, 2'b00, 1'b0, 16'hD3D3, 1'b0, 1'b0, 32'h0},          // R5 store
        '{4'd8, 2'b01, 1'b1, 16'hFFFF, 1'b0, 1'b0, 32'h0},          // R8 fill
        '{4'd8, 2'b11, 1'b0, 16'hEEEE, 1'b0, 1'b0, 32'h0},          // R8 reserved
        '{4'd8, 2'b00, 1'b1, 16'hE3E3, 1'b1, 1'b0, 32'hE3E3D3D3},   // R8 lower kept
        '{4'd7, 2'b00, 1'b0, 16'h1111, 1'b0, 1'b0, 32'h0},          // R7 first lower
        '{4'd7, 2'b00, 1'b0, 16'h2222, 1'b0, 1'b1, 32'h0},          // R7 double lower
        '{4'd7, 2'b00, 1'b1, 16'h3333, 1'b0, 1'b1, 32'h0},          // R7 both dropped
        '{4'd9, 2'b00, 1'b0, 16'h4444, 1'b0, 1'b0, 32'h0},          // R9 store
        '{4'd9, 2'b10, 1'b0, 16'h0000, 1'b0, 1'b0, 32'h0},          // R9 training
        '{4'd9, 2'b00, 1'b1, 16'h5555, 1'b0, 1'b1, 32'h0},          // R9 lower gone
        '{4'd7, 2'b00, 1'b0, 16'h6666, 1'b0, 1'b0, 32'h0},          // R7 resync
        '{4'd7, 2'b00, 1'b1, 16'h7777, 1'b1, 1'b0, 32'h77776666}    // R7 resync word
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tx_seg(input string req, input logic flag, input logic [15:0] data, input logic rdy);
        chk(tx_seg_valid === 1'b1 && tx_seg_flag === flag && tx_seg_data === data && tx_wide_ready === rdy,
            req, {44'h0, tx_seg_valid, tx_seg_flag, tx_wide_ready, tx_seg_data},
            {44'h0, 1'b1, flag, rdy, data});
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        chk(tx_wide_ready === 1'b1, "R10 ready", {63'h0, tx_wide_ready}, 64'h1);
        chk(tx_seg_valid === 1'b0 && rx_wide_valid === 1'b0 && rx_misalign === 1'b0,
            "R10 outputs", {61'h0, tx_seg_valid, rx_wide_valid, rx_misalign}, 64'h0);

        // Table-driven receive checks
        for (int i = 0; i < NV; i++) begin
            rx_seg_kind = VECS[i].kind;
            rx_seg_flag = VECS[i].flag;
            rx_seg_data = VECS[i].din;
            @(negedge clk);
            chk(rx_wide_valid === VECS[i].ev && rx_misalign === VECS[i].ee &&
                (!VECS[i].ev || rx_wide_data === VECS[i].ed),
                $sformatf("R%0d vec%0d", VECS[i].req, i),
                {30'h0, rx_wide_valid, rx_misalign, rx_wide_data},
                {30'h0, VECS[i].ev, VECS[i].ee, VECS[i].ed});
        end
        rx_seg_kind = 2'b01;

        // Transmit directed: R4 idle
        @(negedge clk);
        chk(tx_seg_valid === 1'b0, "R4 idle", {63'h0, tx_seg_valid}, 64'h0);

        tx_wide_data  = 32'hCAFE1234;
        tx_wide_valid = 1'b1;
        @(negedge clk);
        tx_seg("R1 lower first / R3 ready low", 1'b0, 16'h1234, 1'b0);
        tx_wide_data = 32'h56789ABC;
        @(negedge clk);
        tx_seg("R2 upper second / R3 ready back", 1'b1, 16'hCAFE, 1'b1);
        @(negedge clk);
        tx_seg("R3 back-to-back lower", 1'b0, 16'h9ABC, 1'b0);
        tx_wide_valid = 1'b0;
        @(negedge clk);
        tx_seg("R2 back-to-back upper", 1'b1, 16'h5678, 1'b1);
        @(negedge clk);
        chk(tx_seg_valid === 1'b0, "R4 after words", {63'h0, tx_seg_valid}, 64'h0);

        // Offer while pending upper is held off; single word with gap
        tx_wide_data  = 32'h0F0F_F0F0;
        tx_wide_valid = 1'b1;
        @(negedge clk);
        tx_seg("R1 second burst lower", 1'b0, 16'hF0F0, 1'b0);
        tx_wide_valid = 1'b0;
        @(negedge clk);
        tx_seg("R2 second burst upper", 1'b1, 16'h0F0F, 1'b1);

        // Reset in mid-word, R10
        tx_wide_data  = 32'hAAAA_5555;
        tx_wide_valid = 1'b1;
        rx_seg_kind = 2'b00; rx_seg_flag = 1'b0; rx_seg_data = 16'h1357;
        @(negedge clk);
        tx_wide_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rx_seg_flag = 1'b1; rx_seg_data = 16'h2468;
        chk(tx_seg_valid === 1'b0 && tx_wide_ready === 1'b1, "R10 mid-word reset",
            {62'h0, tx_seg_valid, tx_wide_ready}, 64'h1);
        @(negedge clk);
        // stored lower was cleared by reset: orphan upper
        chk(rx_misalign === 1'b1 && rx_wide_valid === 1'b0, "R10 rx lower cleared / R6",
            {62'h0, rx_misalign, rx_wide_valid}, 64'h2);
        rx_seg_kind = 2'b01;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule